// File: doc/BRIEF.md
# Register-Pair Immediate Word Adder

This unit adds or subtracts a small unsigned immediate to or from a 16-bit value. The value is held in a pair of adjacent 8-bit registers. The caller presents four things:
- a 2-bit pair selector,
- the low and high bytes currently held in that pair,
- a 6-bit immediate and an add/subtract select,
- a feature-enable input.

It then pulses `start`. The unit latches the operands and computes the word result in its own cycle. It then presents the new low and high bytes, the index of the even register to write, and updated carry, zero, negative, overflow and sign flags, all for one cycle.

The register file is outside the unit. The caller writes `lo_out` to register `wr_idx` and `hi_out` to `wr_idx + 1` when `wr_en` is high. It also updates only the five flags listed; the half-carry, transfer and interrupt flags are left alone.

When the feature is disabled, no write and no flag update take place. The unit instead raises `unsupported` for one cycle.

The controller is a four-state machine:
- **ST_IDLE**: waits for `start`. Its transition *accept* leads to ST_CALC when `feat_en` is high. Its transition *refuse* leads to ST_REJECT when `feat_en` is low.
- **ST_CALC**: registers the arithmetic result. Its transition *settle* always leads to ST_COMMIT.
- **ST_COMMIT**: drives `wr_en` and `done`. Its transition *retire* returns to ST_IDLE.
- **ST_REJECT**: drives `unsupported`. Its transition *abandon* returns to ST_IDLE.

Top module: `pair_word_adder`

## Requirements
- R1: While `wr_en` is high, `wr_idx` equals 24 + 2·`sel`, where `sel` is the value latched at the accepted start, giving 24, 26, 28 or 30.
- R2: With `sub` low at start, {`hi_out`,`lo_out`} equals ({`hi_in`,`lo_in`} + `imm`) mod 65536.
- R3: With `sub` high at start, {`hi_out`,`lo_out`} equals ({`hi_in`,`lo_in`} − `imm`) mod 65536.
- R4: For an add, `c_out` = old[15] & ~new[15] and `v_out` = new[15] & ~old[15]. Here old is the operand word and new is the result word.
- R5: For a subtract, `c_out` = new[15] & ~old[15] and `v_out` = old[15] & ~new[15].
- R6: `z_out` is 1 exactly when the 16-bit result is 0, `n_out` equals result bit 15, and `s_out` equals `n_out` xor `v_out`.
- R7: A start with `feat_en` low gives `unsupported` high for exactly one cycle, one cycle after the start edge. It gives no `wr_en` and no `done` for that request.
- R8: An accepted start gives `wr_en` and `done` high together for exactly one cycle, in the second cycle after the start edge.
- R9: `start` is ignored while the unit is not in ST_IDLE. The operation in flight completes with its own operands, and no rejection is produced.
- R10: After reset, `wr_en`, `done` and `unsupported` are low and the unit accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled in ST_IDLE |
| feat_en | input | 1 | Feature enable; low means the operation is refused |
| sel | input | 2 | Register pair selector |
| lo_in | input | 8 | Current low byte of the selected pair |
| hi_in | input | 8 | Current high byte of the selected pair |
| imm | input | 6 | Unsigned immediate, 0 to 63 |
| sub | input | 1 | 0 = add, 1 = subtract |
| wr_en | output | 1 | Write both bytes and the five flags this cycle |
| wr_idx | output | 5 | Index of the even (low) register of the pair |
| lo_out | output | 8 | New low byte |
| hi_out | output | 8 | New high byte |
| c_out | output | 1 | Carry/borrow flag |
| z_out | output | 1 | Zero flag |
| n_out | output | 1 | Negative flag |
| v_out | output | 1 | Overflow flag |
| s_out | output | 1 | Sign flag |
| done | output | 1 | Operation completed |
| unsupported | output | 1 | Operation refused because the feature is disabled |

## Verification
The sweep covers every selector, every immediate and both directions over operand words at the edges where bit 15 flips. These edges are 0x0000, 0xFFFF, 0x7FFF, 0x8000 and words just inside 64 of them.

A design that swapped the carry and overflow polarity between add and subtract would mark a wrap through 0xFFFF→0x0000 as overflow rather than carry. A design that took carry from bit 7, or that added the immediate without zero-extending it, would fail near the byte boundary.

Refused requests are checked to produce no write at all. A start pulse that arrives mid-operation is checked to leave the operation's operands intact and to raise no spurious rejection.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REJECT = 2'd3
    } pwa_state_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic s;
    } pwa_flags_t;
endpackage

// File: rtl/pwa_pair_map.sv
module pwa_pair_map #(
    parameter int SEL_W = 2,
    parameter int IDX_W = 5,
    parameter int BASE  = 24
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE);

    always_comb begin
        idx = BASE_V + {IDX_W'(sel), 1'b0} [IDX_W-1:0];
    end
endmodule

// File: rtl/pwa_word_alu.sv
module pwa_word_alu
    import pwa_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IMM_W  = 6
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [IMM_W-1:0]  imm,
    input  logic              sub,
    output logic [WORD_W-1:0] word_out,
    output pwa_flags_t        flags
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] imm_ext;
    logic              old_top;
    logic              new_top;

    always_comb begin
        imm_ext  = {{(WORD_W-IMM_W){1'b0}}, imm};
        word_out = sub ? (word_in - imm_ext) : (word_in + imm_ext);
        old_top  = word_in[MSB];
        new_top  = word_out[MSB];
        if (sub) begin
            flags.c = new_top & ~old_top;
            flags.v = old_top & ~new_top;
        end else begin
            flags.c = old_top & ~new_top;
            flags.v = new_top & ~old_top;
        end
        flags.z = (word_out == '0);
        flags.n = new_top;
        flags.s = new_top ^ flags.v;
    end
endmodule

// File: rtl/pair_word_adder.sv
module pair_word_adder
    import pwa_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IMM_W     = 6,
    parameter int SEL_W     = 2,
    parameter int IDX_W     = 5,
    parameter int PAIR_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              feat_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] lo_in,
    input  logic [DATA_W-1:0] hi_in,
    input  logic [IMM_W-1:0]  imm,
    input  logic              sub,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] lo_out,
    output logic [DATA_W-1:0] hi_out,
    output logic              c_out,
    output logic              z_out,
    output logic              n_out,
    output logic              v_out,
    output logic              s_out,
    output logic              done,
    output logic              unsupported
);
    localparam int WORD_W = 2 * DATA_W;

    pwa_state_e        state_q, state_d;
    logic              idle;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] word_q;
    logic [IMM_W-1:0]  imm_q;
    logic              sub_q;
    logic [WORD_W-1:0] alu_word;
    pwa_flags_t        alu_flags;
    logic [WORD_W-1:0] res_q;
    pwa_flags_t        flags_q;
    logic [IDX_W-1:0]  idx_map;

    assign idle = (state_q == ST_IDLE);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = feat_en ? ST_CALC : ST_REJECT;
            ST_CALC:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            word_q <= '0;
            imm_q  <= '0;
            sub_q  <= 1'b0;
        end else if (idle && start && feat_en) begin
            sel_q  <= sel;
            word_q <= {hi_in, lo_in};
            imm_q  <= imm;
            sub_q  <= sub;
        end
    end

    pwa_word_alu #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_alu (
        .word_in  (word_q),
        .imm      (imm_q),
        .sub      (sub_q),
        .word_out (alu_word),
        .flags    (alu_flags)
    );

    pwa_pair_map #(.SEL_W(SEL_W), .IDX_W(IDX_W), .BASE(PAIR_BASE)) u_map (
        .sel (sel_q),
        .idx (idx_map)
    );

    // result register, loaded in the calculate state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (state_q == ST_CALC) begin
            res_q   <= alu_word;
            flags_q <= alu_flags;
        end
    end

    // outputs
    always_comb begin
        wr_en       = 1'b0;
        done        = 1'b0;
        unsupported = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CALC:   ;
            ST_COMMIT: begin
                wr_en = 1'b1;
                done  = 1'b1;
            end
            ST_REJECT: unsupported = 1'b1;
            default:   ;
        endcase
        wr_idx = idx_map;
        lo_out = res_q[DATA_W-1:0];
        hi_out = res_q[WORD_W-1:DATA_W];
        c_out  = flags_q.c;
        z_out  = flags_q.z;
        n_out  = flags_q.n;
        v_out  = flags_q.v;
        s_out  = flags_q.s;
    end
endmodule

// File: rtl/pwa_checker.sv
module pwa_checker #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              feat_en,
    input logic              idle,
    input logic              wr_en,
    input logic              done,
    input logic              unsupported,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] lo_out,
    input logic [DATA_W-1:0] hi_out,
    input logic              z_out,
    input logic              n_out,
    input logic              v_out,
    input logic              s_out
);
    // R1
    pair_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx[0] == 1'b0 && wr_idx >= IDX_W'(24)));
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (z_out == ({hi_out, lo_out} == '0)));
    // R6
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (s_out == (n_out ^ v_out) && n_out == hi_out[DATA_W-1]));
    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !feat_en) |=> (unsupported && !wr_en));
    // R7
    refuse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |=> !unsupported);
    // R8
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && feat_en) |=> ##1 (wr_en && done));
    // R8
    done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == done);
    // R9
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, unsupported}));
endmodule

bind pair_word_adder pwa_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pwa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .feat_en     (feat_en),
    .idle        (idle),
    .wr_en       (wr_en),
    .done        (done),
    .unsupported (unsupported),
    .wr_idx      (wr_idx),
    .lo_out      (lo_out),
    .hi_out      (hi_out),
    .z_out       (z_out),
    .n_out       (n_out),
    .v_out       (v_out),
    .s_out       (s_out)
);

// File: tb/test_pair_word_adder.sv
module test_pair_word_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       feat_en = 1'b1;
    logic [1:0] sel = '0;
    logic [7:0] lo_in = '0;
    logic [7:0] hi_in = '0;
    logic [5:0] imm = '0;
    logic       sub = 1'b0;
    logic       wr_en, done, unsupported;
    logic [4:0] wr_idx;
    logic [7:0] lo_out, hi_out;
    logic       c_out, z_out, n_out, v_out, s_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pair_word_adder i_pair_word_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat_en), .sel(sel),
        .lo_in(lo_in), .hi_in(hi_in), .imm(imm), .sub(sub),
        .wr_en(wr_en), .wr_idx(wr_idx), .lo_out(lo_out), .hi_out(hi_out),
        .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out), .s_out(s_out),
        .done(done), .unsupported(unsupported)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] s, input logic [15:0] w, input logic [5:0] k,
                          input logic op, input bit poke);
        logic [15:0] r;
        logic        o15, n15, ec, ev;
        r   = op ? (w - {10'd0, k}) : (w + {10'd0, k});
        o15 = w[15];
        n15 = r[15];
        ec  = op ? (n15 & ~o15) : (o15 & ~n15);
        ev  = op ? (o15 & ~n15) : (n15 & ~o15);
        @(negedge clk);
        sel = s; lo_in = w[7:0]; hi_in = w[15:8]; imm = k; sub = op; feat_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: nothing written one cycle after start
        check("R8 early", {30'd0, wr_en, unsupported}, 32'd0);
        if (poke) begin
            // R9: a start mid-flight with other operands and the feature off
            start = 1'b1; feat_en = 1'b0; lo_in = ~lo_in; hi_in = ~hi_in; imm = ~imm; sub = ~sub;
        end
        @(negedge clk);
        start = 1'b0; feat_en = 1'b1;
        check("R8 commit", {30'd0, wr_en, done}, 32'd3);
        check("R1 index", {27'd0, wr_idx}, 32'd24 + 32'd2 * s);
        check(op ? "R3 word" : "R2 word", {16'd0, hi_out, lo_out}, {16'd0, r});
        check(op ? "R5 carry/overflow" : "R4 carry/overflow", {30'd0, c_out, v_out}, {30'd0, ec, ev});
        check("R6 z/n/s", {29'd0, z_out, n_out, s_out}, {29'd0, (r == 16'd0), n15, n15 ^ ev});
        if (poke) check("R9 no refusal", {31'd0, unsupported}, 32'd0);
        @(negedge clk);
        check("R8 single pulse", {30'd0, wr_en, done}, 32'd0);
    endtask

    task automatic run_refused(input logic [1:0] s, input logic [15:0] w, input logic [5:0] k);
        @(negedge clk);
        sel = s; lo_in = w[7:0]; hi_in = w[15:8]; imm = k; sub = 1'b0; feat_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; feat_en = 1'b1;
        check("R7 refused", {29'd0, unsupported, wr_en, done}, 32'd4);
        @(negedge clk);
        check("R7 no write", {29'd0, unsupported, wr_en, done}, 32'd0);
        @(negedge clk);
        check("R7 still no write", {29'd0, unsupported, wr_en, done}, 32'd0);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] words [12];
        words = '{16'h0000, 16'h0001, 16'h003F, 16'h7FC1, 16'h7FFF, 16'h8000,
                  16'h8020, 16'hFFC1, 16'hFFFF, 16'h00FF, 16'h1234, 16'hA5C3};
        repeat (3) @(negedge clk);
        // R10
        check("R10 reset", {29'd0, wr_en, done, unsupported}, 32'd0);
        rst_n = 1'b1;
        for (int wi = 0; wi < 12; wi++)
            for (int si = 0; si < 4; si++)
                for (int ki = 0; ki < 64; ki++)
                    for (int oi = 0; oi < 2; oi++)
                        run_op(si[1:0], words[wi], ki[5:0], oi[0], 1'b0);
        run_refused(2'd1, 16'h1234, 6'd5);
        // R7: a refused request must not disturb the last committed result
        run_op(2'd3, 16'hFFFF, 6'd1, 1'b0, 1'b0);
        run_refused(2'd0, 16'h0000, 6'd63);
        run_op(2'd2, 16'h8000, 6'd1, 1'b1, 1'b1);
        run_op(2'd0, 16'h0000, 6'd63, 1'b1, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule